// File: doc/BRIEF.md
# Macro-op Aligned Reorder Buffer Annulment Unit

This unit cancels the speculative tail of a circular reorder buffer after a mis-speculation. A request names the faulting entry and says whether that entry is kept. A kept entry is usually a mispredicted branch that goes on to commit normally. The unit takes a snapshot of the buffer's head and tail pointers and of the per-entry valid, start-of-instruction and branch-ends-instruction bits. From these it works out where the cancelled range begins. Unless the kept entry is a branch that closes its instruction, the start is pulled back to the nearest entry that opens an instruction. An instruction is therefore never left half cancelled and later executed twice.

On the cycle after the request, the unit outputs a one-cycle squash mask that covers every cancelled entry, so downstream stages can ignore those entries from then on. It then walks the range from the youngest entry to the oldest, one entry per cycle. For each entry it broadcasts the index so issue queues can purge matching slots, and it raises a one-hot free strobe so the entry's register, memory-queue slot and buffer slot can be released. When the walk ends it reports the new tail pointer. Pointers carry one extra wrap bit, so that a full buffer and an empty buffer can be told apart.

Top module: `rob_annul_unit`

## Requirements
- R1: While reset is held, and whenever the unit is idle, busy_o, squash_vld_o, bcast_vld_o and done_o are low and free_o is all zero.
- R2: With keep_i low, the first candidate for cancellation is the faulting entry. With keep_i high, the first candidate is the entry just after it in age order.
- R3: If the candidate entry does not have its start-of-instruction bit set, the range start moves back in age order to the nearest older entry whose bit is set. Entries between that point and the candidate are cancelled too.
- R4: The backward search never goes past the head. If no start-of-instruction bit is set between the head and the candidate, the range starts at the head.
- R5: When keep_i is high and the faulting entry has its branch-ends-instruction bit set, the range starts at the entry after the faulting one and no backward search is made.
- R6: When the candidate lies at the tail, nothing is cancelled. done_o rises on the first cycle after the request, no broadcast is made, and new_tail_o equals the old tail.
- R7: squash_vld_o is high for exactly one cycle, the first cycle after an accepted request. squash_mask_o then has bit j set exactly when entry j is valid and lies between the range start (inclusive) and the tail (exclusive).
- R8: Starting on the first cycle after the request, bcast_vld_o is high for one cycle per cancelled entry. bcast_idx_o steps from the youngest cancelled index down to the oldest, and free_o is the one-hot of bcast_idx_o while bcast_vld_o is high and zero otherwise.
- R9: On the cycle after the last broadcast, done_o is high for one cycle with new_tail_o equal to the range start, including its wrap bit. The unit is idle on the following cycle.
- R10: A request made while busy_o is high is ignored and does not change the ongoing walk.
- R11: Ranges that wrap around the end of the buffer, and a completely full buffer (tail equal to head plus depth), are handled using the pointer wrap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| annul_req_i | input | 1 | Start an annulment (accepted only when idle) |
| fault_idx_i | input | IDX_W | Index of the mis-speculated entry |
| keep_i | input | 1 | Keep the mis-speculated entry |
| head_ptr_i | input | IDX_W+1 | Oldest entry pointer with wrap bit |
| tail_ptr_i | input | IDX_W+1 | Next-free pointer with wrap bit |
| entry_valid_i | input | DEPTH | Per-entry valid bits |
| entry_som_i | input | DEPTH | Per-entry start-of-instruction bits |
| entry_br_end_i | input | DEPTH | Per-entry "branch closing its instruction" bits |
| busy_o | output | 1 | Walk in progress |
| squash_vld_o | output | 1 | Squash mask valid (one cycle) |
| squash_mask_o | output | DEPTH | Entries cancelled by this request |
| bcast_vld_o | output | 1 | Index broadcast valid |
| bcast_idx_o | output | IDX_W | Cancelled entry index being broadcast |
| free_o | output | DEPTH | One-hot release strobe |
| done_o | output | 1 | Walk finished, new tail valid |
| new_tail_o | output | IDX_W+1 | Tail pointer after annulment |

## Verification
Every cycle, the assertions check the framing of the output stream. The unit is silent while idle, each broadcast index is one below the previous one, the free strobe follows the broadcast, the squash mask lasts a single cycle, and done_o is followed by idle. Only the bench scenarios can show where the range starts: backward alignment to an instruction start, the clamp at the head, the exception for a retained closing branch, the empty range, wrap-around and a full buffer. The same holds for the exact mask and the length of the stream. They also cover the filtering of invalid entries and the rejection of a request made while busy.

// File: rtl/rob_annul_pkg.sv
package rob_annul_pkg;
   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;
endpackage

// File: rtl/rob_som_scan.sv
// Finds the nearest instruction start at or below a limit offset,
// working on bits already rotated so that offset 0 is the head.
module rob_som_scan #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] som_rot_i,
   input  logic [IDX_W-1:0] limit_i,
   output logic [IDX_W-1:0] start_off_o
);
   logic [DEPTH-1:0] window;

   for (genvar k = 0; k < DEPTH; k++) begin : g_win
      assign window[k] = som_rot_i[k] && (IDX_W'(k) <= limit_i);
   end

   // highest set bit wins; none set clamps to the head (offset 0)
   always_comb begin
      start_off_o = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (window[k]) start_off_o = IDX_W'(k);
      end
   end
endmodule

// File: rtl/rob_annul_range.sv
// Combinational range calculation: start pointer and squash mask.
module rob_annul_range #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  logic [IDX_W-1:0] fault_idx_i,
   input  logic             keep_i,
   input  logic [PTR_W-1:0] head_ptr_i,
   input  logic [PTR_W-1:0] tail_ptr_i,
   input  logic [DEPTH-1:0] entry_valid_i,
   input  logic [DEPTH-1:0] entry_som_i,
   input  logic [DEPTH-1:0] entry_br_end_i,
   output logic [PTR_W-1:0] start_ptr_o,
   output logic [DEPTH-1:0] squash_mask_o
);
   logic [IDX_W-1:0] head_lo;
   logic [PTR_W-1:0] occ;
   logic [IDX_W-1:0] fault_off;
   logic [PTR_W-1:0] cand;
   logic             empty_range;
   logic             keep_branch;
   logic [DEPTH-1:0] som_rot;
   logic [IDX_W-1:0] scan_off;
   logic [PTR_W-1:0] start_off;

   assign head_lo     = head_ptr_i[IDX_W-1:0];
   assign occ         = tail_ptr_i - head_ptr_i;
   assign fault_off   = fault_idx_i - head_lo;
   assign cand        = {1'b0, fault_off} + PTR_W'(keep_i);
   assign empty_range = (cand >= occ);
   assign keep_branch = keep_i && entry_br_end_i[fault_idx_i];

   for (genvar k = 0; k < DEPTH; k++) begin : g_rot
      logic [IDX_W-1:0] src;
      assign src        = head_lo + IDX_W'(k);
      assign som_rot[k] = entry_som_i[src];
   end

   rob_som_scan #(.DEPTH(DEPTH)) scan_i (
      .som_rot_i  (som_rot),
      .limit_i    (cand[IDX_W-1:0]),
      .start_off_o(scan_off)
   );

   always_comb begin
      if (empty_range)      start_off = occ;
      else if (keep_branch) start_off = cand;
      else                  start_off = {1'b0, scan_off};
   end

   assign start_ptr_o = head_ptr_i + start_off;

   for (genvar j = 0; j < DEPTH; j++) begin : g_mask
      logic [PTR_W-1:0] off_j;
      assign off_j            = {1'b0, IDX_W'(IDX_W'(j) - head_lo)};
      assign squash_mask_o[j] = entry_valid_i[j] && (off_j >= start_off) && (off_j < occ);
   end
endmodule

// File: rtl/rob_annul_walker.sv
// Sequencer: captures the range, pulses the squash mask, then walks
// the range youngest first, one index per cycle.
module rob_annul_walker
   import rob_annul_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_i,
   input  logic [PTR_W-1:0] tail_ptr_i,
   input  logic [PTR_W-1:0] start_ptr_i,
   input  logic [DEPTH-1:0] mask_i,
   output logic             busy_o,
   output logic             squash_vld_o,
   output logic [DEPTH-1:0] squash_mask_o,
   output logic             bcast_vld_o,
   output logic [IDX_W-1:0] bcast_idx_o,
   output logic [DEPTH-1:0] free_o,
   output logic             done_o,
   output logic [PTR_W-1:0] new_tail_o
);
   walk_state_e      state_q;
   logic [PTR_W-1:0] cursor_q;
   logic [PTR_W-1:0] start_q;
   logic             at_start;
   logic [PTR_W-1:0] cursor_dec;

   assign at_start   = (cursor_q == start_q);
   assign cursor_dec = cursor_q - 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q       <= WALK_IDLE;
         cursor_q      <= '0;
         start_q       <= '0;
         squash_vld_o  <= 1'b0;
         squash_mask_o <= '0;
      end else begin
         case (state_q)
            WALK_IDLE: begin
               squash_vld_o <= 1'b0;
               if (req_i) begin
                  state_q       <= WALK_RUN;
                  cursor_q      <= tail_ptr_i;
                  start_q       <= start_ptr_i;
                  squash_vld_o  <= 1'b1;
                  squash_mask_o <= mask_i;
               end
            end
            WALK_RUN: begin
               squash_vld_o <= 1'b0;
               if (at_start) state_q  <= WALK_IDLE;
               else          cursor_q <= cursor_dec;
            end
            default: state_q <= WALK_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q == WALK_RUN);
   assign bcast_vld_o = busy_o && !at_start;
   assign bcast_idx_o = cursor_dec[IDX_W-1:0];
   assign done_o      = busy_o && at_start;
   assign new_tail_o  = start_q;

   for (genvar j = 0; j < DEPTH; j++) begin : g_free
      assign free_o[j] = bcast_vld_o && (bcast_idx_o == IDX_W'(j));
   end
endmodule

// File: rtl/rob_annul_unit.sv
module rob_annul_unit #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             annul_req_i,
   input  logic [IDX_W-1:0] fault_idx_i,
   input  logic             keep_i,
   input  logic [PTR_W-1:0] head_ptr_i,
   input  logic [PTR_W-1:0] tail_ptr_i,
   input  logic [DEPTH-1:0] entry_valid_i,
   input  logic [DEPTH-1:0] entry_som_i,
   input  logic [DEPTH-1:0] entry_br_end_i,
   output logic             busy_o,
   output logic             squash_vld_o,
   output logic [DEPTH-1:0] squash_mask_o,
   output logic             bcast_vld_o,
   output logic [IDX_W-1:0] bcast_idx_o,
   output logic [DEPTH-1:0] free_o,
   output logic             done_o,
   output logic [PTR_W-1:0] new_tail_o
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rob_annul_unit: DEPTH must be a power of two of at least 4");
   end

   logic [PTR_W-1:0] start_ptr;
   logic [DEPTH-1:0] range_mask;

   rob_annul_range #(.DEPTH(DEPTH)) range_i (
      .fault_idx_i   (fault_idx_i),
      .keep_i        (keep_i),
      .head_ptr_i    (head_ptr_i),
      .tail_ptr_i    (tail_ptr_i),
      .entry_valid_i (entry_valid_i),
      .entry_som_i   (entry_som_i),
      .entry_br_end_i(entry_br_end_i),
      .start_ptr_o   (start_ptr),
      .squash_mask_o (range_mask)
   );

   rob_annul_walker #(.DEPTH(DEPTH)) walker_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_i        (annul_req_i),
      .tail_ptr_i   (tail_ptr_i),
      .start_ptr_i  (start_ptr),
      .mask_i       (range_mask),
      .busy_o       (busy_o),
      .squash_vld_o (squash_vld_o),
      .squash_mask_o(squash_mask_o),
      .bcast_vld_o  (bcast_vld_o),
      .bcast_idx_o  (bcast_idx_o),
      .free_o       (free_o),
      .done_o       (done_o),
      .new_tail_o   (new_tail_o)
   );
endmodule

// File: rtl/rob_annul_unit_chk.sv
module rob_annul_unit_chk #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             busy_o,
   input logic             squash_vld_o,
   input logic             bcast_vld_o,
   input logic [IDX_W-1:0] bcast_idx_o,
   input logic [DEPTH-1:0] free_o,
   input logic             done_o
);
   assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (!bcast_vld_o && !done_o && free_o == '0));

   assert_squash_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      squash_vld_o |=> !squash_vld_o);

   assert_bcast_descend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bcast_vld_o && $past(bcast_vld_o)) |-> (bcast_idx_o == IDX_W'($past(bcast_idx_o) - 1'b1)));

   assert_free_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(free_o) && (bcast_vld_o == (free_o != '0)));

   assert_done_then_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !busy_o);

   assert_done_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !bcast_vld_o);
endmodule

bind rob_annul_unit rob_annul_unit_chk #(.DEPTH(DEPTH)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .busy_o      (busy_o),
   .squash_vld_o(squash_vld_o),
   .bcast_vld_o (bcast_vld_o),
   .bcast_idx_o (bcast_idx_o),
   .free_o      (free_o),
   .done_o      (done_o)
);

// File: tb/rob_annul_unit_tb_top.sv
module rob_annul_unit_tb_top;
   localparam int DEPTH = 8;
   localparam int IDX_W = 3;
   localparam int PTR_W = 4;
   localparam int NVEC  = 8;

   // head, tail, fault, keep, som, br_end, expected new tail, expected count
   localparam logic [35:0] VEC [NVEC] = '{
      {4'd0, 4'd6,  3'd3, 1'b0, 8'h25, 8'h00, 4'd2, 4'd4},  // R2 R3 scan back to 2
      {4'd0, 4'd6,  3'd3, 1'b1, 8'h25, 8'h08, 4'd4, 4'd2},  // R5 kept closing branch
      {4'd0, 4'd6,  3'd3, 1'b1, 8'h25, 8'h00, 4'd2, 4'd4},  // R2 R3 keep but not closing
      {4'd0, 4'd6,  3'd5, 1'b0, 8'h25, 8'h00, 4'd5, 4'd1},  // R2 candidate is a start
      {4'd6, 4'd11, 3'd1, 1'b0, 8'h41, 8'h00, 4'd8, 4'd3},  // R11 wrapped range
      {4'd2, 4'd7,  3'd4, 1'b0, 8'h00, 8'h00, 4'd2, 4'd5},  // R4 clamp at head
      {4'd0, 4'd4,  3'd3, 1'b1, 8'h01, 8'h00, 4'd4, 4'd0},  // R6 empty range
      {4'd3, 4'd11, 3'd3, 1'b0, 8'h08, 8'h00, 4'd3, 4'd8}   // R11 full buffer
   };

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic             annul_req_i = 1'b0;
   logic [IDX_W-1:0] fault_idx_i = '0;
   logic             keep_i = 1'b0;
   logic [PTR_W-1:0] head_ptr_i = '0;
   logic [PTR_W-1:0] tail_ptr_i = '0;
   logic [DEPTH-1:0] entry_valid_i = '1;
   logic [DEPTH-1:0] entry_som_i = '0;
   logic [DEPTH-1:0] entry_br_end_i = '0;
   logic             busy_o, squash_vld_o, bcast_vld_o, done_o;
   logic [DEPTH-1:0] squash_mask_o, free_o;
   logic [IDX_W-1:0] bcast_idx_o;
   logic [PTR_W-1:0] new_tail_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #10 clk_i = ~clk_i;

   rob_annul_unit #(.DEPTH(DEPTH)) dut_i (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [PTR_W-1:0] hd, input logic [PTR_W-1:0] tl,
                      input logic [IDX_W-1:0] flt, input logic kp,
                      input logic [DEPTH-1:0] som, input logic [DEPTH-1:0] br,
                      input logic [DEPTH-1:0] vld, input logic [PTR_W-1:0] exp_tail,
                      input int cnt, input bit inject);
      logic [DEPTH-1:0] exp_mask;
      exp_mask = '0;
      for (int k = 0; k < cnt; k++) begin
         logic [IDX_W-1:0] e;
         e = IDX_W'(exp_tail + PTR_W'(k));
         exp_mask[e] = vld[e];
      end
      head_ptr_i = hd; tail_ptr_i = tl; fault_idx_i = flt; keep_i = kp;
      entry_som_i = som; entry_br_end_i = br; entry_valid_i = vld;
      annul_req_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      annul_req_i = 1'b0;
      chk(squash_vld_o == 1'b1, "R7 squash valid", int'(squash_vld_o), 1);
      chk(squash_mask_o == exp_mask, "R7 squash mask", int'(squash_mask_o), int'(exp_mask));
      for (int i = 0; i < cnt; i++) begin
         logic [IDX_W-1:0] ei;
         ei = IDX_W'(tl - PTR_W'(1) - PTR_W'(i));
         chk(bcast_vld_o && bcast_idx_o == ei, "R8 broadcast index", int'(bcast_idx_o), int'(ei));
         chk(free_o == (DEPTH'(1) << ei), "R8 free strobe", int'(free_o), int'(DEPTH'(1) << ei));
         if (i == 1) chk(!squash_vld_o, "R7 squash single cycle", int'(squash_vld_o), 0);
         if (inject && i == 0) begin
            // R10: a request while busy must not disturb the walk
            annul_req_i = 1'b1; fault_idx_i = '0; keep_i = 1'b0; tail_ptr_i = tl + PTR_W'(1);
         end
         @(negedge clk_i);
         annul_req_i = 1'b0;
      end
      chk(done_o && !bcast_vld_o, "R9 done pulse", int'(done_o), 1);
      chk(new_tail_o == exp_tail, "R9 new tail", int'(new_tail_o), int'(exp_tail));
      @(negedge clk_i);
      chk(!busy_o && !done_o, "R9 idle after done", int'(busy_o), 0);
      if (inject) chk(!squash_vld_o, "R10 busy request ignored", int'(squash_vld_o), 0);
   endtask

   initial begin
      forever begin
         @(posedge clk_i);
         cycles++;
         if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk_i);
      chk(!busy_o && !squash_vld_o && !bcast_vld_o && !done_o && free_o == '0,
          "R1 reset quiet", int'(busy_o), 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk(!busy_o && !bcast_vld_o, "R1 idle after reset", int'(busy_o), 0);

      for (int v = 0; v < NVEC; v++) begin
         logic [35:0] t;
         t = VEC[v];
         run(t[35:32], t[31:28], t[27:25], t[24], t[23:16], t[15:8], '1, t[7:4], int'(t[3:0]), 1'b0);
      end

      // R7: an invalid entry inside the range is left out of the mask
      run(4'd0, 4'd6, 3'd3, 1'b0, 8'h25, 8'h00, 8'hDF, 4'd2, 4, 1'b0);
      // R10: request during a walk is ignored
      run(4'd0, 4'd6, 3'd3, 1'b0, 8'h25, 8'h00, 8'hFF, 4'd2, 4, 1'b1);
      // R6 after R10 with stale inputs: a fresh empty request still works
      run(4'd5, 4'd7, 3'd6, 1'b1, 8'h20, 8'h40, 8'hFF, 4'd7, 0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule